// File: doc/BRIEF.md
# CPU Power-Domain Shutdown Sequencer

This block switches off up to three secondary CPU power domains by stepping through a fixed handshake. Each domain has a 7-bit power-control word and an L1 power-down request. In a set order the sequencer isolates the domain and its SRAM, then asks the L1 cache to power down. It waits for the L1 acknowledge. It then takes away reset, clock and both power switches. Last, it waits until the domain reads as off in both power-status vectors. After that it moves on to the next domain.

Software first writes a configuration word with a 16-bit key in its upper half and bit 0 set. A start pulse then names the first domain to shut down. The sequencer works from that domain up to the last one and raises `done` for one cycle at the end. Only one control bit moves per clock, so the step order can be seen on the outputs. Powering a domain back up is outside this block; only a reset returns the words to their powered-on value.

Top module: `pdseq_top`

## Requirements
- R1: After reset every power-control word reads 0x4D (reset_n bit 0, power-on bit 2, second power-on bit 3 and SRAM isolate-interrupt bit 6 set; isolation bit 1, clock-disable bit 4 and SRAM clock isolation bit 5 clear). Every L1 request reads 0, and `busy` and `done` read 0.
- R2: `start` is accepted only if the most recent configuration write held the parameter KEY in bits 31:16 and a 1 in bit 0. Any other start leaves every output unchanged and `busy` low.
- R3: For each domain the first steps are, in this order: set bit 1, set bit 5, clear bit 6, then raise that domain's L1 request (`l1_req[d-1]`).
- R4: After raising the L1 request, the sequencer holds until `l1_ack[d-1]` reads 1. Only then does it clear reset_n.
- R5: After the acknowledge the steps are, in this order: clear bit 0, set bit 4, clear bit 2, clear bit 3. A finished domain therefore reads 0x32 with its L1 request at 1.
- R6: A domain counts as off only when its bit is 0 in both `pwr_sta` and `pwr_sta2`. The bit is at position 10, 11 or 12 for domain 1, 2 or 3. The sequencer holds while either bit is 1, and every other status bit has no effect.
- R7: Domains are handled strictly in ascending order, from `first_dom` through domain 3. Domains below `first_dom` stay untouched. A `first_dom` of 0 is ignored and no output changes.
- R8: `busy` is high from the cycle after an accepted start until the cycle `done` rises. `done` is a single-cycle pulse that follows domain 3 reading off.
- R9: A `start` that arrives while `busy` is high is ignored. The running sequence completes unaltered and produces a single `done`.
- R10: At most one bit of the power-control words and L1 requests changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: key in 31:16, enable in bit 0 |
| start | input | 1 | Start pulse |
| first_dom | input | 2 | First domain to shut down (1 to 3) |
| l1_ack | input | 3 | L1 power-down acknowledge, one bit per domain |
| pwr_sta | input | 32 | Primary power-status vector |
| pwr_sta2 | input | 32 | Secondary power-status vector |
| pctl | output | 21 | Power-control words, 7 bits per domain, domain 1 lowest |
| l1_req | output | 3 | L1 power-down request, one bit per domain |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The shutdown is run from each of the three start domains. Acknowledge and status inputs settle after random delays, and the two status vectors drop at different times. This shows whether each stall waits for its own input and for both vectors, rather than for a fixed count or for only one of them. Unrelated status bits toggle at random throughout, to show that only the domain's own bit is decoded. Start attempts with no key, a wrong key, a clear enable bit, a good key overwritten by a bad one, and a domain index of 0 each expose a different hole in the gating. A second start during a run shows whether a busy sequence can be disturbed.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  localparam int PC_W = 7;

  // Bit positions inside one power-control word
  localparam int B_RSTN   = 0;
  localparam int B_ISO    = 1;
  localparam int B_PON    = 2;
  localparam int B_PON2   = 3;
  localparam int B_CKDIS  = 4;
  localparam int B_SCKISO = 5;
  localparam int B_SISOB  = 6;

  // Powered-on value: reset released, both switches on, SRAM isolate-interrupt high
  localparam logic [PC_W-1:0] PC_ON = 7'h4D;

  typedef enum logic [3:0] {
    OP_NONE, OP_ISO, OP_SCKISO, OP_SISOB, OP_L1REQ,
    OP_RSTN, OP_CKDIS, OP_PON, OP_PON2
  } step_op_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ISO, ST_SCKISO, ST_SISOB, ST_L1REQ, ST_WACK,
    ST_RSTN, ST_CKDIS, ST_PON, ST_PON2, ST_WSTA
  } seq_state_t;
endpackage

// File: rtl/pdseq_keygate.sv
module pdseq_keygate #(
  parameter int CFG_W = 32,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hC3A5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             armed
);
  localparam int KEY_LSB = CFG_W - KEY_W;

  // Each write replaces the previous verdict
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (cfg_we) begin
      armed <= (cfg_wdata[CFG_W-1:KEY_LSB] == KEY) && cfg_wdata[0];
    end
  end
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter int NDOM  = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             armed,
  input  logic [IDX_W-1:0] first_dom,
  input  logic [NDOM-1:0]  l1_ack,
  input  logic [NDOM-1:0]  dom_on_p,
  input  logic [NDOM-1:0]  dom_on_s,
  output step_op_t         op,
  output logic [IDX_W-1:0] op_dom,
  output logic             busy,
  output logic             done
);
  seq_state_t       st;
  logic [IDX_W-1:0] cur;
  logic             ack_sel;
  logic             on_sel;
  logic             first_ok;
  logic             accept;
  logic             last_dom;

  // Pick the handshake inputs of the domain being worked on
  always_comb begin
    ack_sel = 1'b0;
    on_sel  = 1'b0;
    for (int d = 0; d < NDOM; d++) begin
      if (cur == IDX_W'(d + 1)) begin
        ack_sel = l1_ack[d];
        on_sel  = dom_on_p[d] | dom_on_s[d];
      end
    end
  end

  assign first_ok = (first_dom != '0) && (first_dom <= IDX_W'(NDOM));
  assign accept   = start && armed && (st == ST_IDLE) && first_ok;
  assign last_dom = (cur == IDX_W'(NDOM));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cur  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st  <= ST_ISO;
          cur <= first_dom;
        end
        ST_ISO:    st <= ST_SCKISO;
        ST_SCKISO: st <= ST_SISOB;
        ST_SISOB:  st <= ST_L1REQ;
        ST_L1REQ:  st <= ST_WACK;
        ST_WACK:   if (ack_sel) st <= ST_RSTN;
        ST_RSTN:   st <= ST_CKDIS;
        ST_CKDIS:  st <= ST_PON;
        ST_PON:    st <= ST_PON2;
        ST_PON2:   st <= ST_WSTA;
        ST_WSTA: if (!on_sel) begin
          if (last_dom) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            cur <= cur + 1'b1;
            st  <= ST_ISO;
          end
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end

  // One step strobe per state; the register bank applies it on the next edge
  always_comb begin
    case (st)
      ST_ISO:    op = OP_ISO;
      ST_SCKISO: op = OP_SCKISO;
      ST_SISOB:  op = OP_SISOB;
      ST_L1REQ:  op = OP_L1REQ;
      ST_RSTN:   op = OP_RSTN;
      ST_CKDIS:  op = OP_CKDIS;
      ST_PON:    op = OP_PON;
      ST_PON2:   op = OP_PON2;
      default:   op = OP_NONE;
    endcase
  end

  assign op_dom = cur;
  assign busy   = (st != ST_IDLE);
endmodule

// File: rtl/pdseq_domreg.sv
module pdseq_domreg
  import pdseq_pkg::*;
#(
  parameter int NDOM  = 3,
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  step_op_t             op,
  input  logic [IDX_W-1:0]     op_dom,
  output logic [NDOM*PC_W-1:0] pctl,
  output logic [NDOM-1:0]      l1_req
);
  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [PC_W-1:0] word;
    logic            req;
    logic            hit;

    assign hit = (op_dom == IDX_W'(d + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        word <= PC_ON;
        req  <= 1'b0;
      end else if (hit) begin
        case (op)
          OP_ISO:    word[B_ISO]    <= 1'b1;
          OP_SCKISO: word[B_SCKISO] <= 1'b1;
          OP_SISOB:  word[B_SISOB]  <= 1'b0;
          OP_L1REQ:  req            <= 1'b1;
          OP_RSTN:   word[B_RSTN]   <= 1'b0;
          OP_CKDIS:  word[B_CKDIS]  <= 1'b1;
          OP_PON:    word[B_PON]    <= 1'b0;
          OP_PON2:   word[B_PON2]   <= 1'b0;
          default:   ;
        endcase
      end
    end

    assign pctl[d*PC_W +: PC_W] = word;
    assign l1_req[d]            = req;
  end
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int NDOM     = 3,
  parameter int CFG_W    = 32,
  parameter int KEY_W    = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hC3A5,
  parameter int STA_W    = 32,
  parameter int STA_BASE = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [CFG_W-1:0]            cfg_wdata,
  input  logic                        start,
  input  logic [$clog2(NDOM+1)-1:0]   first_dom,
  input  logic [NDOM-1:0]             l1_ack,
  input  logic [STA_W-1:0]            pwr_sta,
  input  logic [STA_W-1:0]            pwr_sta2,
  output logic [NDOM*PC_W-1:0]        pctl,
  output logic [NDOM-1:0]             l1_req,
  output logic                        busy,
  output logic                        done
);
  localparam int IDX_W = $clog2(NDOM + 1);

  logic             armed;
  logic [NDOM-1:0]  dom_on_p;
  logic [NDOM-1:0]  dom_on_s;
  step_op_t         op;
  logic [IDX_W-1:0] op_dom;

  // Only each domain's own status bit is decoded
  for (genvar d = 0; d < NDOM; d++) begin : g_sta
    assign dom_on_p[d] = pwr_sta[STA_BASE + d];
    assign dom_on_s[d] = pwr_sta2[STA_BASE + d];
  end

  pdseq_keygate #(
    .CFG_W(CFG_W),
    .KEY_W(KEY_W),
    .KEY  (KEY)
  ) u_keygate (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .armed    (armed)
  );

  pdseq_fsm #(
    .NDOM (NDOM),
    .IDX_W(IDX_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .armed    (armed),
    .first_dom(first_dom),
    .l1_ack   (l1_ack),
    .dom_on_p (dom_on_p),
    .dom_on_s (dom_on_s),
    .op       (op),
    .op_dom   (op_dom),
    .busy     (busy),
    .done     (done)
  );

  pdseq_domreg #(
    .NDOM (NDOM),
    .IDX_W(IDX_W)
  ) u_domreg (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .op_dom(op_dom),
    .pctl  (pctl),
    .l1_req(l1_req)
  );
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk
  import pdseq_pkg::*;
#(
  parameter int NDOM     = 3,
  parameter int STA_W    = 32,
  parameter int STA_BASE = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NDOM*PC_W-1:0] pctl,
  input logic [NDOM-1:0]      l1_req,
  input logic [NDOM-1:0]      l1_ack,
  input logic [STA_W-1:0]     pwr_sta,
  input logic [STA_W-1:0]     pwr_sta2,
  input logic                 busy,
  input logic                 done
);
  localparam int LAST = STA_BASE + NDOM - 1;

  logic [NDOM*PC_W+NDOM-1:0] ctl_vec;
  logic [NDOM-1:0]           acked;

  assign ctl_vec = {l1_req, pctl};

  // Remembers that a request met its acknowledge at some edge
  always_ff @(posedge clk) begin
    if (rst) acked <= '0;
    else     acked <= acked | (l1_req & l1_ack);
  end

  a_r10_one_bit_step: assert property (@(posedge clk) disable iff (rst)
    $countones(ctl_vec ^ $past(ctl_vec)) <= 1);

  // R2, R7: outputs move only while a sequence runs
  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl_vec) |-> $past(busy));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_done_needs_off: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!pwr_sta[LAST] && !pwr_sta2[LAST]));

  for (genvar d = 0; d < NDOM; d++) begin : g_dchk
    a_r4_rst_after_ack: assert property (@(posedge clk) disable iff (rst)
      $fell(pctl[d*PC_W + B_RSTN]) |-> acked[d]);

    a_r5_rst_after_iso: assert property (@(posedge clk) disable iff (rst)
      $fell(pctl[d*PC_W + B_RSTN]) |->
        (pctl[d*PC_W + B_ISO] && !pctl[d*PC_W + B_SISOB] && l1_req[d]));
  end
endmodule

bind pdseq_top pdseq_chk #(
  .NDOM    (NDOM),
  .STA_W   (STA_W),
  .STA_BASE(STA_BASE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pctl    (pctl),
  .l1_req  (l1_req),
  .l1_ack  (l1_ack),
  .pwr_sta (pwr_sta),
  .pwr_sta2(pwr_sta2),
  .busy    (busy),
  .done    (done)
);

// File: tb/pdseq_top_bench.sv
module pdseq_top_bench;
  localparam int NDOM     = 3;
  localparam int PC_W     = 7;
  localparam int STA_W    = 32;
  localparam int STA_BASE = 10;
  localparam logic [15:0] KEY = 16'hC3A5;
  localparam logic [STA_W-1:0] DMASK = STA_W'(((1 << NDOM) - 1) << STA_BASE);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst = 1'b1;
  logic                 cfg_we = 1'b0;
  logic [31:0]          cfg_wdata = '0;
  logic                 start = 1'b0;
  logic [1:0]           first_dom = '0;
  logic [NDOM-1:0]      l1_ack;
  logic [STA_W-1:0]     pwr_sta;
  logic [STA_W-1:0]     pwr_sta2;
  logic [NDOM*PC_W-1:0] pctl;
  logic [NDOM-1:0]      l1_req;
  logic                 busy;
  logic                 done;

  pdseq_top #(.NDOM(NDOM), .KEY(KEY), .STA_W(STA_W), .STA_BASE(STA_BASE)) u_pdseq_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .start(start),
    .first_dom(first_dom), .l1_ack(l1_ack), .pwr_sta(pwr_sta), .pwr_sta2(pwr_sta2),
    .pctl(pctl), .l1_req(l1_req), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int cyc = 0;

  typedef struct {
    int    dom;
    int    bi;
    logic  val;
    int    gate;
    string tag;
  } exp_t;
  exp_t q[$];

  bit ack_given [NDOM];
  bit sta_off   [NDOM];
  int ack_wait  [NDOM];
  int stp_wait  [NDOM];
  int sts_wait  [NDOM];
  logic [7:0] prev [NDOM];
  logic done_prev;

  function automatic logic [7:0] snap(int d);
    return {l1_req[d], pctl[d*PC_W +: PC_W]};
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) fail(tag, what, act, exp);
  endtask

  // Responder: acknowledge and status drop after random delays
  always @(negedge clk) begin
    if (rst) begin
      l1_ack   = '0;
      pwr_sta  = $urandom() | DMASK;
      pwr_sta2 = $urandom() | DMASK;
      for (int d = 0; d < NDOM; d++) begin
        ack_given[d] = 1'b0;
        sta_off[d]   = 1'b0;
        ack_wait[d]  = $urandom_range(0, 7);
        stp_wait[d]  = $urandom_range(0, 9);
        sts_wait[d]  = $urandom_range(0, 9);
      end
    end else begin
      pwr_sta  = (STA_W'($urandom()) & ~DMASK) | (pwr_sta & DMASK);
      pwr_sta2 = (STA_W'($urandom()) & ~DMASK) | (pwr_sta2 & DMASK);
      for (int d = 0; d < NDOM; d++) begin
        if (l1_req[d] && !l1_ack[d]) begin
          if (ack_wait[d] == 0) begin
            l1_ack[d] = 1'b1;
            ack_given[d] = 1'b1;
          end else ack_wait[d]--;
        end
        if (!pctl[d*PC_W + 3]) begin
          if (stp_wait[d] == 0) pwr_sta[STA_BASE + d] = 1'b0;
          else stp_wait[d]--;
          if (sts_wait[d] == 0) pwr_sta2[STA_BASE + d] = 1'b0;
          else sts_wait[d]--;
          if (!pwr_sta[STA_BASE + d] && !pwr_sta2[STA_BASE + d]) sta_off[d] = 1'b1;
        end
      end
    end
  end

  // Monitor: every output bit change pops and matches the next expected step
  always @(negedge clk) begin
    if (rst) begin
      for (int d = 0; d < NDOM; d++) prev[d] = snap(d);
      done_prev = 1'b0;
    end else begin
      int nchg;
      nchg = 0;
      for (int d = 0; d < NDOM; d++) begin
        logic [7:0] cur;
        cur = snap(d);
        for (int b = 0; b < 8; b++) begin
          if (cur[b] !== prev[d][b]) begin
            nchg++;
            checks++;
            if (q.size() == 0) begin
              fail("R2", $sformatf("unexpected change dom%0d bit%0d", d + 1, b), cur[b], prev[d][b]);
            end else begin
              exp_t e;
              e = q.pop_front();
              if (e.dom != d || e.bi != b || e.val !== cur[b])
                fail(e.tag, "step order (dom*16+bit)", d * 16 + b, e.dom * 16 + e.bi);
              else if (e.gate == 1 && !ack_given[d])
                fail("R4", "reset cleared before acknowledge", 0, 1);
              else if (e.gate == 2 && !sta_off[d-1])
                fail("R6", "next domain began before status drop", 0, 1);
            end
          end
        end
        prev[d] = cur;
      end
      if (nchg > 1) begin
        checks++;
        fail("R10", "bits changed in one cycle", nchg, 1);
      end
      if (done) begin
        done_seen++;
        check(q.size() == 0 && sta_off[NDOM-1] == 1'b1, "R8", "done before last domain off",
              q.size(), 0);
        check(!done_prev, "R8", "done longer than one cycle", 1, 0);
      end
      done_prev = done;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start(logic [1:0] f);
    @(negedge clk);
    start = 1'b1;
    first_dom = f;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_dom(int d, int first);
    int g;
    string t;
    g = (d == first) ? 0 : 2;
    t = (d == first) ? "R3" : "R7";
    q.push_back('{d, 1, 1'b1, g, t});
    q.push_back('{d, 5, 1'b1, 0, "R3"});
    q.push_back('{d, 6, 1'b0, 0, "R3"});
    q.push_back('{d, 7, 1'b1, 0, "R3"});
    q.push_back('{d, 0, 1'b0, 1, "R4"});
    q.push_back('{d, 4, 1'b1, 0, "R5"});
    q.push_back('{d, 2, 1'b0, 0, "R5"});
    q.push_back('{d, 3, 1'b0, 0, "R5"});
  endtask

  task automatic expect_idle(string tag);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, tag, "busy after ignored start", busy, 0);
    for (int d = 0; d < NDOM; d++)
      check(pctl[d*PC_W +: PC_W] == 7'h4D && l1_req[d] == 1'b0, tag,
            $sformatf("dom%0d word after ignored start", d + 1), pctl[d*PC_W +: PC_W], 'h4D);
  endtask

  task automatic run_from(int f, bit poke_busy);
    int n;
    int base;
    base = done_seen;
    for (int d = f - 1; d < NDOM; d++) push_dom(d, f - 1);
    pulse_start(2'(f));
    check(busy == 1'b1, "R8", "busy after accepted start", busy, 1);
    if (poke_busy) pulse_start(2'd1);
    n = 0;
    while (done_seen == base && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (10) @(negedge clk);
    check(done_seen == base + 1, poke_busy ? "R9" : "R8", "done pulses", done_seen - base, 1);
    check(q.size() == 0, "R7", "steps left unobserved", q.size(), 0);
    check(busy == 1'b0, "R8", "busy after done", busy, 0);
    for (int d = 0; d < NDOM; d++) begin
      if (d >= f - 1)
        check(pctl[d*PC_W +: PC_W] == 7'h32 && l1_req[d], "R5",
              $sformatf("dom%0d final word", d + 1), pctl[d*PC_W +: PC_W], 'h32);
      else
        check(pctl[d*PC_W +: PC_W] == 7'h4D && !l1_req[d], "R7",
              $sformatf("dom%0d untouched word", d + 1), pctl[d*PC_W +: PC_W], 'h4D);
    end
  endtask

  initial begin
    reset_dut();
    // R1 reset state
    for (int d = 0; d < NDOM; d++)
      check(pctl[d*PC_W +: PC_W] == 7'h4D, "R1", $sformatf("dom%0d reset word", d + 1),
            pctl[d*PC_W +: PC_W], 'h4D);
    check(l1_req == '0 && busy == 1'b0 && done == 1'b0, "R1", "reset flags",
          {l1_req, busy, done}, 0);

    pulse_start(2'd1);                              // R2 no write at all
    expect_idle("R2");
    cfg_write({16'h1234, 15'd0, 1'b1});             // R2 wrong key
    pulse_start(2'd1);
    expect_idle("R2");
    cfg_write({KEY, 16'h0000});                     // R2 enable bit clear
    pulse_start(2'd1);
    expect_idle("R2");
    cfg_write({KEY, 16'h0001});                     // R2 good key then bad key
    cfg_write({~KEY, 16'h0001});
    pulse_start(2'd1);
    expect_idle("R2");
    cfg_write({KEY, 16'h0001});                     // R7 index 0 ignored
    pulse_start(2'd0);
    expect_idle("R7");

    run_from(1, 1'b1);                              // full run, R9 start while busy

    reset_dut();
    cfg_write({KEY, 16'h0001});
    run_from(3, 1'b0);                              // R7 last domain only

    reset_dut();
    cfg_write({KEY, 16'h8001});
    run_from(2, 1'b0);                              // R6 stalls on two domains

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule